// File: doc/BRIEF.md
# Region-Based Memory Protection Unit

The block screens every bus access against up to eight address windows that software programs for the task now running. Each window covers a range of 8-byte pages, carries its own enable and two restriction flags (writes forbidden, instruction fetches forbidden). When an access breaks the rules, the block asserts an abort in the same cycle as the access strobe and sends a one-cycle non-maskable request to the interrupt controller on the next cycle.

The first violation also records the faulting address and access type in a sticky status. Later violations do not overwrite it until software clears the status. Descriptors are loaded one window at a time through a simple write port. Supervisor code may touch memory that no window covers, and user code may not.

Top module: `mpu_guard`

## Requirements
- R1: A window matches an access when it is enabled and its start page ≤ acc_addr_i[22:3] ≤ its end page, with both bounds inclusive. A disabled window never matches.
- R2: A write (acc_type_i = 2'b01) that hits only windows whose no-write flag is set is aborted.
- R3: An instruction fetch (acc_type_i = 2'b10) that hits only windows whose no-execute flag is set is aborted. A read (acc_type_i = 2'b00) inside any matching window is never aborted.
- R4: When several windows match, the access is allowed if at least one matching window permits it.
- R5: An access that matches no window is aborted when acc_super_i = 0 and allowed when acc_super_i = 1.
- R6: abort_o is combinational and valid in the same cycle as acc_valid_i. It is 0 whenever acc_valid_i is 0.
- R7: nmi_o is high for exactly the cycle after each cycle in which abort_o is high.
- R8: The first abort while the status is empty sets fault_o and latches the access address and type on the next cycle. Further aborts leave these fields unchanged while fault_o is set.
- R9: fault_clr_i clears fault_o on the next cycle. An abort in the same cycle as the clear is not recorded.
- R10: After reset all windows are disabled, fault_o and nmi_o are 0, and fault_addr_o and fault_type_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write descriptor of the selected window |
| cfg_sel_i | input | 3 | Window index |
| cfg_start_i | input | 20 | First page of window (address bits 22:3) |
| cfg_end_i | input | 20 | Last page of window (inclusive) |
| cfg_en_i | input | 1 | Window enable |
| cfg_nw_i | input | 1 | Window forbids writes |
| cfg_nx_i | input | 1 | Window forbids instruction fetch |
| acc_valid_i | input | 1 | Access strobe |
| acc_addr_i | input | 23 | Access byte address |
| acc_type_i | input | 2 | 00 read, 01 write, 10 fetch |
| acc_super_i | input | 1 | Access issued in supervisor mode |
| abort_o | output | 1 | Access violation, same cycle |
| nmi_o | output | 1 | Non-maskable violation request pulse |
| fault_clr_i | input | 1 | Clear fault status |
| fault_o | output | 1 | Fault status pending |
| fault_addr_o | output | 23 | Address of first recorded violation |
| fault_type_o | output | 2 | Access type of first recorded violation |

## Verification
The hardest case to reach is overlapping windows with conflicting flags. A write must land on a page that two enabled windows cover, where only one of them forbids the write. The bench builds this by stacking a write-protected window and a permissive window over a shared page range, and then probing pages inside and outside the overlap. It uses the same approach to check the sticky status: it issues two different violations back to back, then a violation in the same cycle as the clear. This shows that only the first violation is kept and that the clear wins when both happen together.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  localparam int unsigned ADDR_W = 23;
  localparam int unsigned GRAN_BITS = 3;
  localparam int unsigned PAGE_W = ADDR_W - GRAN_BITS;
  localparam int unsigned TYPE_W = 2;

  localparam logic [TYPE_W-1:0] ACC_READ  = 2'b00;
  localparam logic [TYPE_W-1:0] ACC_WRITE = 2'b01;
  localparam logic [TYPE_W-1:0] ACC_FETCH = 2'b10;

  typedef struct packed {
    logic [PAGE_W-1:0] first;
    logic [PAGE_W-1:0] last;
    logic              en;
    logic              no_wr;
    logic              no_ex;
  } win_desc_t;
endpackage

// File: rtl/mpu_window.sv
module mpu_window
  import mpu_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  win_desc_t           desc_i,
  input  logic [PAGE_W-1:0]   page_i,
  input  logic [TYPE_W-1:0]   type_i,
  output logic                hit_o,
  output logic                allow_o
);
  win_desc_t desc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) desc_q <= '0;
    else if (we_i) desc_q <= desc_i;
  end

  logic deny;
  always_comb begin
    hit_o = desc_q.en && (page_i >= desc_q.first) && (page_i <= desc_q.last);
    unique case (type_i)
      ACC_WRITE: deny = desc_q.no_wr;
      ACC_FETCH: deny = desc_q.no_ex;
      default:   deny = 1'b0;
    endcase
    allow_o = hit_o && !deny;
  end
endmodule

// File: rtl/mpu_fault_log.sv
module mpu_fault_log
  import mpu_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                abort_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [TYPE_W-1:0]   type_i,
  input  logic                clr_i,
  output logic                nmi_o,
  output logic                fault_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [TYPE_W-1:0]   type_o
);
  logic capture;
  assign capture = abort_i && !fault_o && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_o   <= 1'b0;
      fault_o <= 1'b0;
      addr_o  <= '0;
      type_o  <= '0;
    end else begin
      nmi_o <= abort_i;
      if (clr_i) fault_o <= 1'b0;
      else if (capture) begin
        fault_o <= 1'b1;
        addr_o  <= addr_i;
        type_o  <= type_i;
      end
    end
  end

  // R7
  a_r7_nmi_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> nmi_o);
  a_r7_nmi_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_i |=> !nmi_o);
  // R8
  a_r8_first_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !fault_o && !clr_i) |=> (fault_o && addr_o == $past(addr_i)
                                        && type_o == $past(type_i)));
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !clr_i) |=> (fault_o && $stable(addr_o) && $stable(type_o)));
  // R9
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !fault_o);
endmodule

// File: rtl/mpu_guard.sv
module mpu_guard
  import mpu_pkg::*;
#(
  parameter int unsigned N_WIN = 8,
  localparam int unsigned SEL_W = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [SEL_W-1:0]    cfg_sel_i,
  input  logic [PAGE_W-1:0]   cfg_start_i,
  input  logic [PAGE_W-1:0]   cfg_end_i,
  input  logic                cfg_en_i,
  input  logic                cfg_nw_i,
  input  logic                cfg_nx_i,
  input  logic                acc_valid_i,
  input  logic [ADDR_W-1:0]   acc_addr_i,
  input  logic [TYPE_W-1:0]   acc_type_i,
  input  logic                acc_super_i,
  output logic                abort_o,
  output logic                nmi_o,
  input  logic                fault_clr_i,
  output logic                fault_o,
  output logic [ADDR_W-1:0]   fault_addr_o,
  output logic [TYPE_W-1:0]   fault_type_o
);
  win_desc_t          wdesc;
  logic [N_WIN-1:0]   hit, allow;
  logic [PAGE_W-1:0]  page;

  assign page  = acc_addr_i[ADDR_W-1:GRAN_BITS];
  assign wdesc = '{first: cfg_start_i, last: cfg_end_i, en: cfg_en_i,
                   no_wr: cfg_nw_i, no_ex: cfg_nx_i};

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    mpu_window u_win (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (cfg_we_i && (cfg_sel_i == SEL_W'(g))),
      .desc_i (wdesc),
      .page_i (page),
      .type_i (acc_type_i),
      .hit_o  (hit[g]),
      .allow_o(allow[g])
    );
  end

  // matched: any permitting window grants; unmatched: only supervisor passes
  always_comb begin
    if (!acc_valid_i)  abort_o = 1'b0;
    else if (|hit)     abort_o = ~|allow;
    else               abort_o = !acc_super_i;
  end

  mpu_fault_log u_log (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .abort_i(abort_o),
    .addr_i (acc_addr_i),
    .type_i (acc_type_i),
    .clr_i  (fault_clr_i),
    .nmi_o  (nmi_o),
    .fault_o(fault_o),
    .addr_o (fault_addr_o),
    .type_o (fault_type_o)
  );

  // R6
  a_r6_idle_no_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> !abort_o);
  // R3
  a_r3_read_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_type_i == ACC_READ && (|hit)) |-> !abort_o);
  // R5
  a_r5_super_unmapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_super_i && !(|hit)) |-> !abort_o);
endmodule

// File: tb/mpu_guard_test.sv
module mpu_guard_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_sel_i = '0;
  logic [19:0] cfg_start_i = '0, cfg_end_i = '0;
  logic        cfg_en_i = 1'b0, cfg_nw_i = 1'b0, cfg_nx_i = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic [22:0] acc_addr_i = '0;
  logic [1:0]  acc_type_i = '0;
  logic        acc_super_i = 1'b0;
  logic        fault_clr_i = 1'b0;
  logic        abort_o, nmi_o, fault_o;
  logic [22:0] fault_addr_o;
  logic [1:0]  fault_type_o;

  int checks = 0, errors = 0;

  mpu_guard uut (.*);

  always #5 clk_i = ~clk_i;

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic prog(int idx, logic [19:0] s, logic [19:0] e, logic en, logic nw, logic nx);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_sel_i = 3'(idx); cfg_start_i = s; cfg_end_i = e;
    cfg_en_i = en; cfg_nw_i = nw; cfg_nx_i = nx;
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  // drive access at negedge; abort sampled same cycle; strobe dropped at next negedge
  task automatic probe(logic [22:0] a, logic [1:0] t, logic sup, logic exp, string req);
    @(negedge clk_i);
    acc_valid_i = 1; acc_addr_i = a; acc_type_i = t; acc_super_i = sup;
    #1 chk(req, abort_o, exp);
    @(negedge clk_i);
    acc_valid_i = 0;
    chk({req, " R7 nmi"}, nmi_o, exp);
  endtask

  task automatic t_reset;
    chk("R10 fault", fault_o, 0);
    chk("R10 nmi", nmi_o, 0);
    chk("R10 addr", fault_addr_o, 0);
    chk("R10 type", fault_type_o, 0);
    chk("R6 idle", abort_o, 0);
    probe(23'h100, 2'b00, 1'b0, 1'b1, "R10 user unmapped");
    probe(23'h100, 2'b00, 1'b1, 1'b0, "R5 super unmapped");
    @(negedge clk_i); fault_clr_i = 1; @(negedge clk_i); fault_clr_i = 0;
  endtask

  task automatic t_bounds;
    prog(0, 20'h00010, 20'h0001F, 1, 1, 0);
    probe(23'h00080, 2'b00, 0, 0, "R1 start edge");
    probe(23'h000FF, 2'b00, 0, 0, "R1 end edge");
    probe(23'h0007F, 2'b00, 0, 1, "R1 below start");
    probe(23'h00100, 2'b00, 0, 1, "R1 above end");
    probe(23'h00080, 2'b01, 0, 1, "R2 no-write");
    probe(23'h00080, 2'b10, 0, 0, "R3 fetch ok in nw window");
    probe(23'h00080, 2'b01, 1, 1, "R2 no-write supervisor");
  endtask

  task automatic t_nx;
    prog(1, 20'h00100, 20'h00100, 1, 0, 1);
    probe(23'h00800, 2'b10, 0, 1, "R3 no-exec");
    probe(23'h00807, 2'b00, 0, 0, "R3 read in nx window");
    probe(23'h00800, 2'b01, 0, 0, "R2 write in nx window");
  endtask

  task automatic t_overlap;
    prog(2, 20'h00018, 20'h00030, 1, 0, 0);
    probe(23'h000C0, 2'b01, 0, 0, "R4 overlap write allowed");
    probe(23'h00088, 2'b01, 0, 1, "R4 outside overlap blocked");
    prog(2, 20'h00018, 20'h00030, 0, 0, 0);
    probe(23'h000C0, 2'b01, 0, 1, "R1 disabled window ignored");
    probe(23'h00110, 2'b01, 0, 1, "R1 disabled unmapped user");
  endtask

  task automatic t_status;
    @(negedge clk_i); fault_clr_i = 1; @(negedge clk_i); fault_clr_i = 0;
    chk("R9 cleared", fault_o, 0);
    probe(23'h00088, 2'b01, 0, 1, "R8 first");
    chk("R8 flag", fault_o, 1);
    chk("R8 addr", fault_addr_o, 23'h00088);
    chk("R8 type", fault_type_o, 2'b01);
    probe(23'h00800, 2'b10, 0, 1, "R8 second");
    chk("R8 addr kept", fault_addr_o, 23'h00088);
    chk("R8 type kept", fault_type_o, 2'b01);
    // clear together with a violation: violation not recorded
    @(negedge clk_i);
    fault_clr_i = 1; acc_valid_i = 1; acc_addr_i = 23'h00800; acc_type_i = 2'b10; acc_super_i = 0;
    #1 chk("R9 abort same cycle", abort_o, 1);
    @(negedge clk_i);
    fault_clr_i = 0; acc_valid_i = 0;
    chk("R9 clear wins", fault_o, 0);
    chk("R7 nmi on clear cycle", nmi_o, 1);
    @(negedge clk_i);
    chk("R7 nmi one cycle", nmi_o, 0);
    chk("R9 stays clear", fault_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset;
    t_bounds;
    t_nx;
    t_overlap;
    t_status;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule